// File: doc/BRIEF.md
# Secure Doorbell Mailbox

This block is a memory-mapped doorbell unit through which two processors signal each other. It has two independent channels, one per direction. Each channel holds a 32-bit status word and has three registers: a status register that can be read, a set register and a clear register. A processor rings a doorbell by writing ones into the peer channel's set register. The receiver sees a level interrupt, reads the status, and acknowledges by writing ones to the clear register.

Status bits 30..0 are doorbell slots. Bit 31 is not a slot. Hardware raises it when a non-secure write reaches any register of that channel, and such a write changes no slot. Non-secure reads return zero. The register bus is a single-cycle synchronous port with address, write enable, write data, a secure attribute and read data. Read data is combinational from the address.

Top module: `dbell_mailbox`

## Requirements
- R1: Channel A (interrupt `irq_to_first`) has its status register at 0x200, its set register at 0x208 and its clear register at 0x210. Channel B (interrupt `irq_to_second`) uses 0x300, 0x308 and 0x310 for the same three registers.
- R2: A secure write to a set register raises every status bit in 30..0 whose write-data bit is one. The other status bits are left unchanged. The new status is readable on the cycle after the write.
- R3: A secure write to a clear register lowers every status bit whose write-data bit is one. The other status bits are left unchanged. The new status is readable on the cycle after the write.
- R4: Synchronous active-low reset sets both status words to zero and drives both interrupts low.
- R5: Bit 31 of a secure set write is ignored, so status bit 31 is never raised by software.
- R6: A non-secure write to any of a channel's three registers leaves status bits 30..0 unchanged and sets status bit 31 of that channel only.
- R7: Status bit 31 stays high until a secure write to that channel's clear register has data bit 31 at one.
- R8: A non-secure read of any address returns zero.
- R9: Reads of set registers, clear registers and unmapped offsets return zero. Writes to a status register or to an unmapped offset change no status bit.
- R10: Each interrupt output is high exactly when any bit of its channel's status word is one.
- R11: A write to one channel never changes the other channel's status word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write enable; the write takes effect at this rising edge |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | 1 = secure access, 0 = non-secure |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_to_first | output | 1 | Level interrupt for channel A |
| irq_to_second | output | 1 | Level interrupt for channel B |

## Verification
The main test is a sequence of writes run from reset. After each write the bench reads both status words and both interrupts. The writes include single-slot and multi-slot sets, partial clears, and a set that includes bit 31 (which must be dropped). They also include non-secure writes to set, clear and status registers, writes to status registers and to a gap in the map, and clears that do or do not include bit 31. This sequence separates a design that masks the slot field correctly from one that lets bit 31 through. It also catches a design that lets non-secure data leak into the slots, one that flags the wrong channel, and one that clears the flag too easily. Directed reads then confirm zero data for non-secure, set, clear and unmapped addresses, and a reset applied mid-run must clear everything.

// File: rtl/dbell_pkg.sv
// Package: shared constants for the doorbell mailbox.
// Assumes a 32-bit data path in which bit 31 is the non-secure access flag.
package dbell_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_CH    = 2;
    localparam int FLAG_BIT  = DATA_W - 1;
    localparam int CH_STRIDE = 'h100;
    localparam int CH_BASE0  = 'h200;
    localparam int OFF_STAT  = 'h00;
    localparam int OFF_SET   = 'h08;
    localparam int OFF_CLR   = 'h10;
    localparam logic [DATA_W-1:0] SLOT_MASK = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] FLAG_MASK = {1'b1, {(DATA_W-1){1'b0}}};

    // Base byte address of channel ch.
    function automatic int ch_base(input int ch);
        return CH_BASE0 + ch * CH_STRIDE;
    endfunction
endpackage

// File: rtl/dbell_decode.sv
// Module: dbell_decode
// Decodes one channel's three register addresses from the bus.
// Assumes single-cycle accesses. Set and clear strobes are secure-only.
// A non-secure write to any of the three addresses yields ns_wr.
module dbell_decode #(
    parameter int ADDR_W = 12,
    parameter int BASE   = 'h200
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              secure,
    output logic              stat_rd,
    output logic              set_wr,
    output logic              clr_wr,
    output logic              ns_wr
);
    import dbell_pkg::*;

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE + OFF_STAT);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(BASE + OFF_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(BASE + OFF_CLR);

    logic hit_stat, hit_set, hit_clr;

    // Compare the address against the channel's three registers.
    always_comb begin
        hit_stat = (addr == A_STAT);
        hit_set  = (addr == A_SET);
        hit_clr  = (addr == A_CLR);
    end

    // Form strobes qualified by direction and security attribute.
    always_comb begin
        stat_rd = hit_stat && secure;
        set_wr  = hit_set && we && secure;
        clr_wr  = hit_clr && we && secure;
        ns_wr   = (hit_stat || hit_set || hit_clr) && we && !secure;
    end
endmodule

// File: rtl/dbell_channel.sv
// Module: dbell_channel
// Holds one channel's status word and drives its level interrupt.
// Assumes the strobes come from dbell_decode: set_wr and clr_wr are
// secure-only, and ns_wr marks a non-secure write to this channel.
module dbell_channel (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_wr,
    input  logic                        clr_wr,
    input  logic                        ns_wr,
    input  logic [dbell_pkg::DATA_W-1:0] wdata,
    output logic [dbell_pkg::DATA_W-1:0] status,
    output logic                        irq
);
    import dbell_pkg::*;

    logic [DATA_W-1:0] set_vec, clr_vec, flag_vec, status_nxt;

    // Build per-source bit vectors; the set path never touches bit 31.
    always_comb begin
        set_vec  = set_wr ? (wdata & SLOT_MASK) : '0;
        clr_vec  = clr_wr ? wdata : '0;
        flag_vec = ns_wr ? FLAG_MASK : '0;
    end

    // Clear first, then OR in sets and the flag, so a set beats a clear.
    always_comb status_nxt = (status & ~clr_vec) | set_vec | flag_vec;

    // Status register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= status_nxt;
    end

    // Level interrupt while any bit is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |status_nxt;
    end

    // R4: status is zero on the first cycle after reset.
    assert_reset_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (status == '0 && !irq));

    // R2: every slot named in a secure set write is high next cycle.
    assert_set_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((status & $past(wdata & SLOT_MASK)) == $past(wdata & SLOT_MASK)));

    // R3: every bit named in a secure clear write is low next cycle.
    assert_clear_lowers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !set_wr && !ns_wr) |=> ((status & $past(wdata)) == '0));

    // R6: a non-secure write keeps the slots and raises the flag.
    assert_ns_keeps_slots_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ns_wr && !set_wr && !clr_wr) |=>
            (status[FLAG_BIT] && status[FLAG_BIT-1:0] == $past(status[FLAG_BIT-1:0])));

    // R7: the flag survives any cycle without a secure clear of bit 31.
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status[FLAG_BIT] && !(clr_wr && wdata[FLAG_BIT])) |=> status[FLAG_BIT]);

    // R10: the interrupt tracks any pending bit.
    assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (status != '0));
endmodule

// File: rtl/dbell_mailbox.sv
// Module: dbell_mailbox (top)
// Two-channel secure doorbell mailbox on a single-cycle register bus.
// Assumes one access per cycle and combinational read data.
// Non-secure reads return zero.
module dbell_mailbox #(
    parameter int ADDR_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_we,
    input  logic [dbell_pkg::DATA_W-1:0] bus_wdata,
    input  logic                         bus_secure,
    output logic [dbell_pkg::DATA_W-1:0] bus_rdata,
    output logic                         irq_to_first,
    output logic                         irq_to_second
);
    import dbell_pkg::*;

    logic [NUM_CH-1:0]             stat_rd;
    logic [NUM_CH-1:0]             irq_v;
    logic [DATA_W-1:0]             status_v [NUM_CH];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic set_wr, clr_wr, ns_wr;

        dbell_decode #(
            .ADDR_W (ADDR_W),
            .BASE   (ch_base(ch))
        ) u_dec (
            .addr    (bus_addr),
            .we      (bus_we),
            .secure  (bus_secure),
            .stat_rd (stat_rd[ch]),
            .set_wr  (set_wr),
            .clr_wr  (clr_wr),
            .ns_wr   (ns_wr)
        );

        dbell_channel u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_wr (set_wr),
            .clr_wr (clr_wr),
            .ns_wr  (ns_wr),
            .wdata  (bus_wdata),
            .status (status_v[ch]),
            .irq    (irq_v[ch])
        );
    end

    // Read mux: only a secure status address returns data.
    always_comb begin
        bus_rdata = '0;
        for (int ch = 0; ch < NUM_CH; ch++)
            if (stat_rd[ch]) bus_rdata = bus_rdata | status_v[ch];
    end

    // Map the channel interrupts onto named outputs.
    always_comb begin
        irq_to_first  = irq_v[0];
        irq_to_second = irq_v[1];
    end

    // R8: a non-secure access never returns data.
    assert_ns_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_secure |-> (bus_rdata == '0));
endmodule

// File: tb/sim_dbell_mailbox.sv
`timescale 1ns/1ps
module sim_dbell_mailbox;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_secure = 1'b1;
    logic [31:0]   bus_rdata;
    logic          irq_to_first, irq_to_second;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    dbell_mailbox #(.ADDR_W(AW)) u0 (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_we (bus_we),
        .bus_wdata (bus_wdata), .bus_secure (bus_secure), .bus_rdata (bus_rdata),
        .irq_to_first (irq_to_first), .irq_to_second (irq_to_second)
    );

    typedef struct packed {
        logic        sec;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp_a;
        logic [31:0] exp_b;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h208, 32'h0000_0005, 32'h0000_0005, 32'h0, 8'd2},           // R2
        '{1'b1, 12'h208, 32'h0000_0100, 32'h0000_0105, 32'h0, 8'd2},           // R2
        '{1'b1, 12'h308, 32'h8000_0003, 32'h0000_0105, 32'h3, 8'd5},           // R5
        '{1'b1, 12'h210, 32'h0000_0004, 32'h0000_0101, 32'h3, 8'd3},           // R3
        '{1'b0, 12'h208, 32'h0000_00F0, 32'h8000_0101, 32'h3, 8'd6},           // R6
        '{1'b0, 12'h310, 32'h0000_0003, 32'h8000_0101, 32'h8000_0003, 8'd6},   // R6
        '{1'b1, 12'h210, 32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0003, 8'd7},   // R7
        '{1'b1, 12'h208, 32'h8000_0000, 32'h8000_0000, 32'h8000_0003, 8'd5},   // R5
        '{1'b1, 12'h200, 32'h0000_FFFF, 32'h8000_0000, 32'h8000_0003, 8'd9},   // R9
        '{1'b1, 12'h204, 32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0003, 8'd9},   // R9
        '{1'b1, 12'h210, 32'h8000_0000, 32'h0, 32'h8000_0003, 8'd7},           // R7
        '{1'b1, 12'h310, 32'hFFFF_FFFF, 32'h0, 32'h0, 8'd3},                   // R3
        '{1'b1, 12'h308, 32'h4000_0000, 32'h0, 32'h4000_0000, 8'd11},          // R11
        '{1'b0, 12'h300, 32'h0000_0000, 32'h0, 32'hC000_0000, 8'd6}            // R6
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Write issued after a falling edge, captured at the next rising edge.
    task automatic do_write(input logic sec, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_secure = sec; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_secure = 1'b1; bus_wdata = '0;
    endtask

    task automatic do_read(input logic sec, input logic [11:0] a, output logic [31:0] d);
        bus_we = 1'b0; bus_secure = sec; bus_addr = a;
        #1 d = bus_rdata;
        bus_secure = 1'b1;
    endtask

    task automatic check_state(input string tag, input logic [31:0] ea, input logic [31:0] eb);
        logic [31:0] rd;
        do_read(1'b1, 12'h200, rd); check({tag, " R1 status A"}, rd, ea);
        do_read(1'b1, 12'h300, rd); check({tag, " R1 status B"}, rd, eb);
        check({tag, " R10 irq A"}, {31'b0, irq_to_first},  {31'b0, ea != 0});
        check({tag, " R10 irq B"}, {31'b0, irq_to_second}, {31'b0, eb != 0});
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R4 reset", 32'h0, 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_write(VECS[i].sec, VECS[i].addr, VECS[i].data);
            check_state($sformatf("vec%0d R%0d", i, VECS[i].req), VECS[i].exp_a, VECS[i].exp_b);
        end

        // R8: non-secure reads of a populated status return zero.
        do_read(1'b0, 12'h300, rd); check("R8 ns read status B", rd, 32'h0);
        do_read(1'b0, 12'h200, rd); check("R8 ns read status A", rd, 32'h0);
        // R9: set, clear and unmapped reads return zero.
        do_read(1'b1, 12'h308, rd); check("R9 read set B", rd, 32'h0);
        do_read(1'b1, 12'h210, rd); check("R9 read clear A", rd, 32'h0);
        do_read(1'b1, 12'h2FC, rd); check("R9 read unmapped", rd, 32'h0);
        // R9: a non-secure write to an unmapped offset raises no flag.
        do_write(1'b0, 12'h400, 32'hFFFF_FFFF);
        check_state("R9 ns unmapped", 32'h0, 32'hC000_0000);
        // R11: a write to A leaves B unchanged.
        do_write(1'b1, 12'h208, 32'h0000_0001);
        check_state("R11 A only", 32'h1, 32'hC000_0000);

        // R4: reset in mid-run clears both channels.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check_state("R4 mid reset", 32'h0, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule